// File: doc/BRIEF.md
# Quadrature Position Decoder with Qualified Index Clear

The block turns the two phase signals and the index signal of an incremental encoder into a position count and a direction flag. Each encoder input first crosses into the clock domain through a two-flop synchronizer. An optional glitch filter can then clean it: a channel takes a new level only after that level has been seen on three prescaled sample ticks in a row. The prescaler's divide ratio comes from a 3-bit code.

The decoder can run at four counts per encoder cycle (every phase edge) or at two counts per encoder cycle (phase A edges only). A rising index edge clears the position, but only when the phase levels at that moment match a programmed two-bit pattern. The pattern is read one way in four-count mode and another way in two-count mode. When both phases change in the same sample, the step is illegal. It leaves the count unchanged and raises an error pulse, which can also drive an interrupt line that software can mask.

Top module: `quad_decoder`

## Requirements
- R1: After reset, pos_o, dir_o, filt_a_o, filt_b_o, filt_idx_o, count_err_o and err_irq_o are all 0.
- R2: With x4_mode_i=1, every sample in which exactly one phase changes moves pos_o by one. The step is up (+1) when the new A level differs from the previous B level, otherwise down (-1). The forward sequence (A,B) 00→10→11→01→00 counts up.
- R3: With x4_mode_i=0, only phase A edges move pos_o. The step is up when A differs from B after the edge. B edges alone leave pos_o unchanged.
- R4: dir_o becomes 1 after an up step and 0 after a down step, and holds its value otherwise.
- R5: When A and B change in the same sample, count_err_o pulses high for one cycle and pos_o does not change.
- R6: err_irq_o pulses together with count_err_o when err_irq_dis_i=0. It stays 0 when err_irq_dis_i=1, even though count_err_o still pulses.
- R7: With x4_mode_i=1, a rising index edge clears pos_o to 0 only if B equals idx_match_i[1] and A equals idx_match_i[0]. Otherwise pos_o is unchanged.
- R8: With x4_mode_i=0, idx_match_i[1] selects the phase to test (0 = A, 1 = B). A rising index edge clears pos_o only if that phase equals idx_match_i[0]. An index clear takes priority over a count step in the same sample.
- R9: With the filter enabled, a channel output takes a new level only after three consecutive sample ticks see that level. A pulse seen on fewer ticks is ignored.
- R10: filt_div_i codes 0 to 7 give one sample tick every 1, 2, 4, 16, 32, 64, 128 and 256 clock cycles respectively. No code gives a divide by 8.
- R11: With filt_en_i=1, the filtered A, B and index levels appear on filt_a_o, filt_b_o and filt_idx_o, and they feed the decoder. With filt_en_i=0, those outputs are 0 and the decoder uses the synchronized raw inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Raw encoder phase A |
| enc_b_i | input | 1 | Raw encoder phase B |
| enc_idx_i | input | 1 | Raw encoder index |
| filt_en_i | input | 1 | Filter enable and filtered-output enable |
| filt_div_i | input | 3 | Filter sample-tick divide code |
| x4_mode_i | input | 1 | 1 = four counts per cycle, 0 = two counts per cycle |
| idx_match_i | input | 2 | Phase pattern that qualifies an index clear |
| err_irq_dis_i | input | 1 | 1 = mask the count-error interrupt |
| pos_o | output | POS_W | Position count |
| dir_o | output | 1 | Direction of the last step (1 = up) |
| filt_a_o | output | 1 | Filtered phase A (0 when filter disabled) |
| filt_b_o | output | 1 | Filtered phase B (0 when filter disabled) |
| filt_idx_o | output | 1 | Filtered index (0 when filter disabled) |
| count_err_o | output | 1 | One-cycle pulse on an illegal phase transition |
| err_irq_o | output | 1 | Maskable error interrupt pulse |

## Verification
Assertions check four things on every cycle. A filter output changes only right after a sample tick. The position moves by at most one unless it is cleared to zero. An error sample leaves the position untouched, and the interrupt never fires without the error flag. Direction changes only together with a position change. Other behaviours can only be shown by the bench's scenarios. These are the direction sign for each transition order, the two readings of the index match pattern, glitch rejection, and the exact prescaler ratio (16 for code 3, which is not 8).

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned DIV_CODE_W = 3;
  localparam int unsigned DIV_CNT_W  = 8;

  // sparse divide table: 1,2,4,16,32,64,128,256 (no /8)
  function automatic logic [3:0] div_shift(input logic [DIV_CODE_W-1:0] code);
    logic [3:0] s;
    if (code < 3'd3) s = {1'b0, code};
    else             s = {1'b0, code} + 4'd1;
    return s;
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler
  import qdec_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_CODE_W-1:0] div_i,
  output logic                  tick_o
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W:0]   span;
  logic [DIV_CNT_W:0]   limit;

  always_comb begin
    span  = ({{DIV_CNT_W{1'b0}}, 1'b1}) << div_shift(div_i);
    limit = span - 1'b1;
  end

  assign tick_o = ({1'b0, cnt_q} >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int unsigned STABLE_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned HIST_W = STABLE_N - 1;

  logic [HIST_W-1:0] hist_q;
  logic [STABLE_N-1:0] window;
  logic q_q;

  assign window = {hist_q, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      q_q    <= 1'b0;
    end else if (tick_i) begin
      hist_q <= window[HIST_W-1:0];
      if (&window)       q_q <= 1'b1;
      else if (~|window) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  // R9: output level may only move on a sample tick
  a_r9_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> $past(tick_i));
endmodule

// File: rtl/qdec_core.sv
module qdec_core #(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             idx_i,
  input  logic             x4_i,
  input  logic [1:0]       match_i,
  input  logic             irq_dis_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             err_o,
  output logic             irq_o
);
  logic a_q, b_q, idx_q;
  logic [POS_W-1:0] pos_q;
  logic dir_q, err_q, irq_q;
  logic a_chg, b_chg, illegal, step_en, step_up, idx_rise, match_ok, phase_sel;

  always_comb begin
    a_chg     = a_i ^ a_q;
    b_chg     = b_i ^ b_q;
    illegal   = a_chg & b_chg;
    step_en   = x4_i ? (a_chg ^ b_chg) : (a_chg & ~b_chg);
    step_up   = a_i ^ b_q;
    idx_rise  = idx_i & ~idx_q;
    phase_sel = match_i[1] ? b_i : a_i;
    match_ok  = x4_i ? ((b_i == match_i[1]) && (a_i == match_i[0]))
                     : (phase_sel == match_i[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      idx_q <= 1'b0;
      pos_q <= '0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      idx_q <= idx_i;
      err_q <= illegal;
      irq_q <= illegal & ~irq_dis_i;
      if (idx_rise && match_ok) begin
        pos_q <= '0;
      end else if (step_en) begin
        pos_q <= step_up ? pos_q + 1'b1 : pos_q - 1'b1;
        dir_q <= step_up;
      end
    end
  end

  assign pos_o = pos_q;
  assign dir_o = dir_q;
  assign err_o = err_q;
  assign irq_o = irq_q;

  // R5: an illegal sample never moves the count
  a_r5_err_holds_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (pos_q == $past(pos_q)));
  // R6: interrupt only with the error flag
  a_r6_irq_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> err_q);
  // R2/R3: single-unit steps or a clear
  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + 1'b1) ||
    (pos_q == $past(pos_q) - 1'b1) || (pos_q == '0));
  // R4: direction only moves with a count step
  a_r4_dir_with_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_q) |-> !$stable(pos_q));
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STABLE_N    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enc_a_i,
  input  logic                  enc_b_i,
  input  logic                  enc_idx_i,
  input  logic                  filt_en_i,
  input  logic [DIV_CODE_W-1:0] filt_div_i,
  input  logic                  x4_mode_i,
  input  logic [1:0]            idx_match_i,
  input  logic                  err_irq_dis_i,
  output logic [POS_W-1:0]      pos_o,
  output logic                  dir_o,
  output logic                  filt_a_o,
  output logic                  filt_b_o,
  output logic                  filt_idx_o,
  output logic                  count_err_o,
  output logic                  err_irq_o
);
  localparam int unsigned NCH = 3;

  logic [NCH-1:0] sync_s, filt_s, dec_s;
  logic tick;

  qdec_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({enc_idx_i, enc_b_i, enc_a_i}),
    .q_o   (sync_s)
  );

  qdec_prescaler u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (filt_div_i),
    .tick_o(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    qdec_filter #(.STABLE_N(STABLE_N)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .d_i   (sync_s[g]),
      .q_o   (filt_s[g])
    );
  end

  assign dec_s = filt_en_i ? filt_s : sync_s;

  qdec_core #(.POS_W(POS_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (dec_s[0]),
    .b_i      (dec_s[1]),
    .idx_i    (dec_s[2]),
    .x4_i     (x4_mode_i),
    .match_i  (idx_match_i),
    .irq_dis_i(err_irq_dis_i),
    .pos_o    (pos_o),
    .dir_o    (dir_o),
    .err_o    (count_err_o),
    .irq_o    (err_irq_o)
  );

  assign filt_a_o   = filt_en_i & filt_s[0];
  assign filt_b_o   = filt_en_i & filt_s[1];
  assign filt_idx_o = filt_en_i & filt_s[2];
endmodule

// File: tb/tb_quad_decoder.sv
module tb_quad_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 0, b = 0, idx = 0, fen = 0, x4 = 1, idis = 0;
  logic [2:0] fdiv = 0;
  logic [1:0] match = 0;
  logic [15:0] pos;
  logic dir, fa, fb, fi, cerr, irq;
  int n_chk = 0, n_fail = 0, err_seen = 0, irq_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b), .enc_idx_i(idx),
    .filt_en_i(fen), .filt_div_i(fdiv), .x4_mode_i(x4), .idx_match_i(match),
    .err_irq_dis_i(idis), .pos_o(pos), .dir_o(dir), .filt_a_o(fa),
    .filt_b_o(fb), .filt_idx_o(fi), .count_err_o(cerr), .err_irq_o(irq)
  );

  always @(negedge clk) begin
    if (cerr) err_seen++;
    if (irq)  irq_seen++;
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; a = 0; b = 0; idx = 0; fen = 0; x4 = 1; idis = 0; fdiv = 0; match = 0;
    wait_clk(2);
    rst_n = 1;
    wait_clk(2);
    err_seen = 0; irq_seen = 0;
  endtask

  task automatic step(input logic na, input logic nb);
    @(negedge clk); a = na; b = nb;
    wait_clk(6);
  endtask

  task automatic pulse_idx();
    @(negedge clk); idx = 1;
    wait_clk(6);
    idx = 0;
    wait_clk(6);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pos", pos, 0);
    chk("R1 dir", dir, 0);
    chk("R1 filt", {fa, fb, fi}, 0);
    chk("R1 err", {cerr, irq}, 0);
  endtask

  task automatic t_x4();
    do_reset();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    chk("R2 up x4", pos, 4);
    chk("R4 dir up", dir, 1);
    step(0, 1); step(1, 1);
    chk("R2 down x4", pos, 2);
    chk("R4 dir down", dir, 0);
  endtask

  task automatic t_x2();
    do_reset();
    x4 = 0;
    step(1, 0);
    chk("R3 A edge", pos, 1);
    step(1, 1);
    chk("R3 B edge ignored", pos, 1);
    step(0, 1); step(0, 0);
    chk("R3 full cycle", pos, 2);
  endtask

  task automatic t_err();
    do_reset();
    step(1, 1);
    chk("R5 err pulse", err_seen, 1);
    chk("R5 pos held", pos, 0);
    chk("R6 irq enabled", irq_seen, 1);
    idis = 1;
    step(0, 0);
    chk("R6 err still flagged", err_seen, 2);
    chk("R6 irq masked", irq_seen, 1);
    chk("R5 pos held again", pos, 0);
  endtask

  task automatic t_idx4();
    do_reset();
    step(1, 0); step(1, 1);
    match = 2'b00;
    pulse_idx();
    chk("R7 mismatch keeps", pos, 2);
    match = 2'b11;
    pulse_idx();
    chk("R7 match clears", pos, 0);
  endtask

  task automatic t_idx2();
    do_reset();
    x4 = 0; match = 2'b10;
    step(1, 0);
    pulse_idx();
    chk("R8 B low clears", pos, 0);
    step(1, 1); step(0, 1);
    chk("R8 setup count", pos, 1);
    pulse_idx();
    chk("R8 B high keeps", pos, 1);
    match = 2'b11;
    pulse_idx();
    chk("R8 select B level 1 clears", pos, 0);
  endtask

  task automatic t_filter();
    do_reset();
    fen = 1; fdiv = 0;
    @(negedge clk); a = 1;
    wait_clk(10);
    chk("R11 filt_a out", fa, 1);
    chk("R11 decode via filter", pos, 1);
    @(negedge clk); b = 1;
    @(negedge clk); b = 0;
    wait_clk(10);
    chk("R9 glitch filt_b", fb, 0);
    chk("R9 glitch no count", pos, 1);
    fen = 0;
    wait_clk(2);
    chk("R11 outputs off", {fa, fb, fi}, 0);
    fen = 1; fdiv = 3;
    @(negedge clk); a = 0;
    wait_clk(30);
    chk("R10 code3 not yet", fa, 1);
    wait_clk(30);
    chk("R10 code3 accepted", fa, 0);
    chk("R10 count after filter", pos, 0);
  endtask

  initial begin
    t_reset();
    t_x4();
    t_x2();
    t_err();
    t_idx4();
    t_idx2();
    t_filter();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule